// File: doc/BRIEF.md
# Gshare Conditional Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds one global history register with the most recent resolved outcomes. It also holds a pattern table of 2-bit saturating counters. A fetch stage presents a branch address on the lookup port. In the same cycle the block returns a taken/not-taken guess and the table index it used. The pipeline carries that index along with the branch.

When the branch resolves, the back end presents three things on the update port: the real outcome, the saved index and a flag that says whether the guess was wrong. On the next clock edge the addressed counter moves one step toward the outcome and the history register takes in the outcome. The table index mixes the word address with the whole history by a bitwise XOR, so a short index still uses every history bit. The history length and the table's address width are the same parameter.

Top module: `gshare_pred`

## Requirements
- R1: The lookup index `lk_idx_o` equals PC bits [IDX_W+1:2] XOR the global history register, and it changes in the same cycle as `lk_pc_i` (combinational).
- R2: `lk_taken_o` is the most significant bit of the counter at `lk_idx_o`. Counter encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. After reset, even entries hold 01 and odd entries hold 10.
- R3: PC bits [1:0] and the PC bits above IDX_W+1 have no effect on the index or on the prediction.
- R4: An update with `up_taken_i`=1 raises the addressed counter by one and holds it at 11 once it is there.
- R5: An update with `up_taken_i`=0 lowers the addressed counter by one and holds it at 00 once it is there.
- R6: Reset clears the history register to zero. Each update shifts the history left by one place and puts the outcome (1 taken, 0 not taken) in bit 0. Without an update the history holds its value.
- R7: Updates take effect at the clock edge. A lookup of the entry being updated in the same cycle returns the old counter value.
- R8: An update writes only the entry named by `up_idx_i` and never an index recomputed from the current history. All other entries keep their values.
- R9: The update is suppressed when `up_mispred_i`=0 and the counter is already saturated in the outcome's direction. A correct prediction on a counter that is not saturated still trains it, and a wrong prediction always trains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | Address of the branch being looked up |
| lk_taken_o | output | 1 | Predicted direction, 1 means taken |
| lk_idx_o | output | IDX_W | Table index used for this lookup |
| up_valid_i | input | 1 | Update request for the current cycle |
| up_idx_i | input | IDX_W | Index saved when the branch was looked up |
| up_taken_i | input | 1 | Resolved outcome, 1 means taken |
| up_mispred_i | input | 1 | The earlier prediction was wrong |

## Verification
Streams of all-taken and all-not-taken outcomes drive counters into both saturation limits. A single reversal afterwards then shows whether the counter stopped at 11 or 00, or kept going past it. Mixed outcome streams, checked through the index returned for address zero, show the history's shift direction and the bit position the outcome enters. A lookup and an update aimed at one entry in the same cycle show whether the read comes before the write. A final sweep of every entry against a reference table shows whether updates land at the saved index or at a recomputed one.

// File: rtl/gsh_pkg.sv
package gsh_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SN = 2'b00;
  localparam ctr_t CTR_WN = 2'b01;
  localparam ctr_t CTR_WT = 2'b10;
  localparam ctr_t CTR_ST = 2'b11;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == CTR_ST) ? c : ctr_t'(c + 2'd1);
    else       return (c == CTR_SN) ? c : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_sat(ctr_t c, logic taken);
    return taken ? (c == CTR_ST) : (c == CTR_SN);
  endfunction
endpackage

// File: rtl/gsh_index.sv
module gsh_index #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned PC_W  = 32
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IDX_W-1:0] ghr_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned LO = 2;
  localparam int unsigned HI = IDX_W + LO - 1;

  assign idx_o = pc_i[HI:LO] ^ ghr_i;

  // byte offset bits never reach the table
  logic unused_lo;
  assign unused_lo = ^pc_i[LO-1:0];

  generate
    if (PC_W > HI + 1) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pc_i[PC_W-1:HI+1];
    end
  endgenerate
endmodule

// File: rtl/gsh_history.sv
module gsh_history #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [IDX_W-1:0] ghr_o
);
  logic [IDX_W-1:0] ghr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ghr_q <= '0;
    else if (shift_i) ghr_q <= {ghr_q[IDX_W-2:0], bit_i};
  end

  assign ghr_o = ghr_q;
endmodule

// File: rtl/gsh_pht.sv
module gsh_pht
  import gsh_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              widx_i,
  input  ctr_t                          wdata_i,
  output ctr_t [(1 << IDX_W)-1:0]       tbl_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam ctr_t RST_V = (i % 2 == 1) ? CTR_WT : CTR_WN;
      ctr_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= RST_V;
        else if (we_i && (widx_i == IDX_W'(i)))      q <= wdata_i;
      end
      assign tbl_o[i] = q;
    end
  endgenerate
endmodule

// File: rtl/gshare_pred.sv
module gshare_pred
  import gsh_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             lk_taken_o,
  output logic [IDX_W-1:0] lk_idx_o,
  input  logic             up_valid_i,
  input  logic [IDX_W-1:0] up_idx_i,
  input  logic             up_taken_i,
  input  logic             up_mispred_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  ghr_q;
  ctr_t [DEPTH-1:0]  tbl;
  ctr_t              up_cur, up_nxt, lk_ctr;
  logic              up_we;

  gsh_index #(.IDX_W(IDX_W), .PC_W(PC_W)) u_idx (
    .pc_i  (lk_pc_i),
    .ghr_i (ghr_q),
    .idx_o (lk_idx_o)
  );

  gsh_history #(.IDX_W(IDX_W)) u_ghr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (up_valid_i),
    .bit_i   (up_taken_i),
    .ghr_o   (ghr_q)
  );

  // read-before-write: lookup sees the pre-edge table
  assign lk_ctr     = tbl[lk_idx_o];
  assign lk_taken_o = lk_ctr[1];

  assign up_cur = tbl[up_idx_i];
  assign up_nxt = ctr_next(up_cur, up_taken_i);
  // skip the write when a correct guess finds the counter already saturated
  assign up_we  = up_valid_i && (up_mispred_i || !ctr_sat(up_cur, up_taken_i));

  gsh_pht #(.IDX_W(IDX_W)) u_pht (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (up_we),
    .widx_i  (up_idx_i),
    .wdata_i (up_nxt),
    .tbl_o   (tbl)
  );
endmodule

// File: rtl/gshare_pred_chk.sv
module gshare_pred_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           up_valid_i,
  input logic [IDX_W-1:0]               up_idx_i,
  input logic                           up_taken_i,
  input logic [IDX_W-1:0]               lk_idx_o,
  input logic [IDX_W-1:0]               ghr_i,
  input logic [(1 << IDX_W)-1:0][1:0]   tbl_i
);
  p_hist_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> ghr_i == {$past(ghr_i[IDX_W-2:0]), $past(up_taken_i)});

  p_hist_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(ghr_i));

  p_sat_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_taken_i && tbl_i[up_idx_i] == 2'b11)
      |=> tbl_i[$past(up_idx_i)] == 2'b11);

  p_sat_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_taken_i && tbl_i[up_idx_i] == 2'b00)
      |=> tbl_i[$past(up_idx_i)] == 2'b00);

  p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_taken_i && tbl_i[up_idx_i] != 2'b11)
      |=> tbl_i[$past(up_idx_i)] == 2'($past(tbl_i[up_idx_i]) + 2'd1));

  p_step_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !up_taken_i && tbl_i[up_idx_i] != 2'b00)
      |=> tbl_i[$past(up_idx_i)] == 2'($past(tbl_i[up_idx_i]) - 2'd1));

  p_no_touch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && lk_idx_o != up_idx_i)
      |=> tbl_i[$past(lk_idx_o)] == $past(tbl_i[lk_idx_o]));
endmodule

bind gshare_pred gshare_pred_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_valid_i (up_valid_i),
  .up_idx_i   (up_idx_i),
  .up_taken_i (up_taken_i),
  .lk_idx_o   (lk_idx_o),
  .ghr_i      (ghr_q),
  .tbl_i      (tbl)
);

// File: tb/sim_gshare_pred.sv
module sim_gshare_pred;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [31:0]      lk_pc_i = '0;
  logic             lk_taken_o;
  logic [IDX_W-1:0] lk_idx_o;
  logic             up_valid_i = 1'b0;
  logic [IDX_W-1:0] up_idx_i = '0;
  logic             up_taken_i = 1'b0;
  logic             up_mispred_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [IDX_W-1:0] ghr_m;
  logic [1:0]       cnt_m [DEPTH];

  always #10 clk_i = ~clk_i;

  gshare_pred #(.IDX_W(IDX_W), .PC_W(32)) u0 (
    .clk_i, .rst_ni, .lk_pc_i, .lk_taken_o, .lk_idx_o,
    .up_valid_i, .up_idx_i, .up_taken_i, .up_mispred_i
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pc_for(int e, logic [1:0] lo, logic [21:0] hi);
    logic [IDX_W-1:0] w;
    w = IDX_W'(e) ^ ghr_m;
    return {hi, w, lo};
  endfunction

  task automatic read_entry(input int e, output logic tk);
    @(negedge clk_i);
    lk_pc_i = pc_for(e, 2'b00, '0);
    #1;
    chk(lk_idx_o == IDX_W'(e), "R1 index", int'(lk_idx_o), e);
    tk = lk_taken_o;
  endtask

  task automatic expect_pred(input int e, input logic exp, input string req);
    logic tk;
    read_entry(e, tk);
    chk(tk == exp, req, int'(tk), int'(exp));
  endtask

  function automatic logic [1:0] nxt(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic upd(input int e, input logic t, input logic m);
    @(negedge clk_i);
    up_valid_i = 1'b1; up_idx_i = IDX_W'(e); up_taken_i = t; up_mispred_i = m;
    @(posedge clk_i); #1;
    cnt_m[e] = nxt(cnt_m[e], t);
    ghr_m = {ghr_m[IDX_W-2:0], t};
    @(negedge clk_i);
    up_valid_i = 1'b0;
    lk_pc_i = '0;
    #1;
    chk(lk_idx_o == ghr_m, "R6 history shift", int'(lk_idx_o), int'(ghr_m));
  endtask

  task automatic t_reset;
    lk_pc_i = '0; #1;
    chk(lk_idx_o == '0, "R6 history clear", int'(lk_idx_o), 0);
    expect_pred(5, 1'b1, "R2 odd reset weak taken");
    expect_pred(4, 1'b0, "R2 even reset weak not-taken");
  endtask

  task automatic t_pc_bits;
    logic [IDX_W-1:0] i0;
    logic t0;
    @(negedge clk_i);
    lk_pc_i = pc_for(9, 2'b00, '0); #1;
    i0 = lk_idx_o; t0 = lk_taken_o;
    lk_pc_i = pc_for(9, 2'b11, 22'h2aa55); #1;
    chk(lk_idx_o == i0, "R3 ignored pc bits idx", int'(lk_idx_o), int'(i0));
    chk(lk_taken_o == t0, "R3 ignored pc bits pred", int'(lk_taken_o), int'(t0));
  endtask

  task automatic t_sat_up;
    for (int k = 0; k < 3; k++) upd(40, 1'b1, 1'b0);
    expect_pred(40, 1'b1, "R4 rises to taken");
    upd(40, 1'b0, 1'b1);
    expect_pred(40, 1'b1, "R4 held at 11");
  endtask

  task automatic t_sat_dn;
    for (int k = 0; k < 3; k++) upd(41, 1'b0, 1'b0);
    expect_pred(41, 1'b0, "R5 falls to not-taken");
    upd(41, 1'b1, 1'b1);
    expect_pred(41, 1'b0, "R5 held at 00");
  endtask

  task automatic t_history;
    upd(3, 1'b1, 1'b0); upd(3, 1'b0, 1'b0);
    upd(3, 1'b1, 1'b1); upd(3, 1'b1, 1'b0);
    chk(ghr_m[3:0] == 4'b1011, "R6 outcome order", int'(ghr_m[3:0]), 11);
  endtask

  task automatic t_collide;
    @(negedge clk_i);
    lk_pc_i = pc_for(10, 2'b00, '0);
    up_valid_i = 1'b1; up_idx_i = IDX_W'(10); up_taken_i = 1'b1; up_mispred_i = 1'b1;
    #1;
    chk(lk_taken_o == cnt_m[10][1], "R7 same-cycle old value", int'(lk_taken_o), int'(cnt_m[10][1]));
    @(posedge clk_i); #1;
    cnt_m[10] = nxt(cnt_m[10], 1'b1);
    ghr_m = {ghr_m[IDX_W-2:0], 1'b1};
    @(negedge clk_i);
    up_valid_i = 1'b0;
    expect_pred(10, cnt_m[10][1], "R7 new value after edge");
  endtask

  task automatic t_mispred_flag;
    upd(20, 1'b1, 1'b1); upd(20, 1'b1, 1'b1);
    upd(20, 1'b1, 1'b0);
    upd(20, 1'b0, 1'b1);
    expect_pred(20, 1'b1, "R9 saturated skip keeps 11");
    upd(22, 1'b0, 1'b0);
    upd(22, 1'b1, 1'b1);
    expect_pred(22, 1'b0, "R9 correct guess still trains");
  endtask

  task automatic t_sweep;
    logic tk;
    int bad = 0;
    for (int e = 0; e < DEPTH; e++) begin
      read_entry(e, tk);
      if (tk != cnt_m[e][1]) begin
        bad++;
        chk(1'b0, "R8 entry mismatch", e, int'(cnt_m[e][1]));
      end
    end
    chk(bad == 0, "R8 sweep", bad, 0);
  endtask

  initial begin
    ghr_m = '0;
    for (int i = 0; i < DEPTH; i++) cnt_m[i] = (i % 2 == 1) ? 2'b10 : 2'b01;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset;
    t_pc_bits;
    t_sat_up;
    t_sat_dn;
    t_history;
    t_collide;
    t_mispred_flag;
    t_sweep;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule